// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load-Use Interlock

This block sits beside the decode stage of a five-stage in-order pipeline. It decides where each of the two decode-stage source operands should come from: the register file, or a result still travelling down the pipe. It also decides whether the front of the pipe must hold for one cycle because a load has not yet returned its data. Forwarding is resolved in decode rather than in execute. Branch compares made in decode therefore see current register values.

Inputs are the decode instruction's two source register numbers and flags saying whether it actually reads them. From the execute and memory stages come the destination register number, the register-write flag and the memory-to-register (load) flag. The block also contains the two 4-way operand multiplexers. It returns the two selects and the resolved operands.

It has three further outputs:
- A stall flag.
- A write enable for the program counter and the fetch/decode register.
- A cancel flag. The decode logic uses it to squash the register and memory writes of the instruction held in decode during a stall. That instruction is presented again on the next cycle, so without the squash it would execute twice.

The block is purely combinational and keeps no state. There are no states and no transitions: every output follows its inputs within the same cycle.

Top module: `decode_hazard_unit`

## Requirements
- R1: With no qualifying match in execute or memory, a select is 0 and its operand equals the register-file read data.
- R2: When the execute stage writes a register (write flag 1, load flag 0) whose number is non-zero and equals the source, the select is 1 and the operand is the execute ALU result.
- R3: When the memory stage writes a non-zero register equal to the source, the select is 3 with load data as the operand if its load flag is 1, and 2 with the memory ALU result as the operand otherwise.
- R4: A qualifying execute-stage match overrides a memory-stage match on the same source.
- R5: Register 0 is never forwarded: a source of 0 always gives select 0.
- R6: Stall is 1 exactly when all of the following hold: the execute write flag is 1, the execute load flag is 1, the execute destination is non-zero, and that destination equals a source that is marked as used.
- R7: The PC / fetch-decode write enable is the inverse of stall.
- R8: Cancel is 1 exactly when stall is 1.
- R9: Each operand output equals the input named by its select: 0 register file, 1 execute ALU, 2 memory ALU, 3 memory load data.
- R10: A load in the execute stage never produces select 1, even when its destination matches.
- R11: A source whose use flag is 0 never causes a stall, even if it matches a load destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 5 | First source register number in decode |
| id_rt | input | 5 | Second source register number in decode |
| id_use_rs | input | 1 | Decode instruction reads the first source |
| id_use_rt | input | 1 | Decode instruction reads the second source |
| ex_dst | input | 5 | Destination register number in execute |
| ex_wreg | input | 1 | Execute instruction writes a register |
| ex_m2reg | input | 1 | Execute instruction is a load |
| mem_dst | input | 5 | Destination register number in memory stage |
| mem_wreg | input | 1 | Memory-stage instruction writes a register |
| mem_m2reg | input | 1 | Memory-stage instruction is a load |
| rf_qa | input | 32 | Register-file data for the first source |
| rf_qb | input | 32 | Register-file data for the second source |
| ex_alu | input | 32 | Execute-stage ALU result |
| mem_alu | input | 32 | Memory-stage ALU result |
| mem_load | input | 32 | Memory-stage load data |
| fwd_a | output | 2 | Select for the first operand |
| fwd_b | output | 2 | Select for the second operand |
| op_a | output | 32 | Resolved first operand |
| op_b | output | 32 | Resolved second operand |
| stall | output | 1 | Load-use interlock active |
| pc_ifid_we | output | 1 | Write enable for PC and fetch/decode register |
| cancel | output | 1 | Squash writes of the decode instruction |

## Verification
The embedded assertions check several properties whenever the inputs are known. A load in execute never yields select 1, and a select of 1 never names register 0. A memory-stage select never wins over a qualifying execute match. A select of 0 passes register-file data through, and stall only occurs with a load in execute.

Some behaviour only the bench can show, because it needs a model of the intended function:
- the exact stall condition, including the role of the use flags;
- the choice between load data and ALU result in the memory stage;
- the full agreement of both selects and operands with a behavioural reference.

The bench covers these over directed corners and a long run of random stage contents with register numbers drawn from a small range, so that matches are frequent.

// File: rtl/dhu_pkg.sv
package dhu_pkg;
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_EX_ALU  = 2'd1,
        SRC_MEM_ALU = 2'd2,
        SRC_MEM_LD  = 2'd3
    } src_sel_e;
endpackage

// File: rtl/dhu_src_select.sv
module dhu_src_select
    import dhu_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wreg,
    input  logic             ex_m2reg,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wreg,
    input  logic             mem_m2reg,
    output src_sel_e         sel
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic ex_hit;
    logic mem_hit;

    always_comb begin
        ex_hit  = ex_wreg && !ex_m2reg && (ex_dst != ZERO_REG) && (ex_dst == src);
        mem_hit = mem_wreg && (mem_dst != ZERO_REG) && (mem_dst == src);
        unique case ({ex_hit, mem_hit})
            2'b10, 2'b11: sel = SRC_EX_ALU;
            2'b01:        sel = mem_m2reg ? SRC_MEM_LD : SRC_MEM_ALU;
            default:      sel = SRC_REGFILE;
        endcase
    end
endmodule

// File: rtl/dhu_operand_mux.sv
module dhu_operand_mux
    import dhu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  src_sel_e        sel,
    input  logic [XLEN-1:0] rf_data,
    input  logic [XLEN-1:0] ex_alu,
    input  logic [XLEN-1:0] mem_alu,
    input  logic [XLEN-1:0] mem_load,
    output logic [XLEN-1:0] operand
);
    always_comb begin
        unique case (sel)
            SRC_EX_ALU:  operand = ex_alu;
            SRC_MEM_ALU: operand = mem_alu;
            SRC_MEM_LD:  operand = mem_load;
            default:     operand = rf_data;
        endcase
    end
endmodule

// File: rtl/dhu_load_interlock.sv
module dhu_load_interlock #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_use_rs,
    input  logic             id_use_rt,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wreg,
    input  logic             ex_m2reg,
    output logic             stall,
    output logic             front_we,
    output logic             squash
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic load_in_ex;
    logic dep_rs;
    logic dep_rt;

    always_comb begin
        load_in_ex = ex_wreg && ex_m2reg && (ex_dst != ZERO_REG);
        dep_rs     = id_use_rs && (ex_dst == id_rs);
        dep_rt     = id_use_rt && (ex_dst == id_rt);
        stall      = load_in_ex && (dep_rs || dep_rt);
        front_we   = !stall;
        squash     = stall;
    end
endmodule

// File: rtl/decode_hazard_unit.sv
module decode_hazard_unit
    import dhu_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int XLEN  = 32
) (
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_use_rs,
    input  logic             id_use_rt,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wreg,
    input  logic             ex_m2reg,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wreg,
    input  logic             mem_m2reg,
    input  logic [XLEN-1:0]  rf_qa,
    input  logic [XLEN-1:0]  rf_qb,
    input  logic [XLEN-1:0]  ex_alu,
    input  logic [XLEN-1:0]  mem_alu,
    input  logic [XLEN-1:0]  mem_load,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic [XLEN-1:0]  op_a,
    output logic [XLEN-1:0]  op_b,
    output logic             stall,
    output logic             pc_ifid_we,
    output logic             cancel
);
    localparam int NUM_SRC = 2;

    logic [REG_W-1:0] src_num [NUM_SRC];
    logic [XLEN-1:0]  src_rf  [NUM_SRC];
    logic [XLEN-1:0]  src_op  [NUM_SRC];
    src_sel_e         src_sel [NUM_SRC];

    assign src_num[0] = id_rs;
    assign src_num[1] = id_rt;
    assign src_rf[0]  = rf_qa;
    assign src_rf[1]  = rf_qb;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        dhu_src_select #(.REG_W(REG_W)) u_sel (
            .src       (src_num[g]),
            .ex_dst    (ex_dst),
            .ex_wreg   (ex_wreg),
            .ex_m2reg  (ex_m2reg),
            .mem_dst   (mem_dst),
            .mem_wreg  (mem_wreg),
            .mem_m2reg (mem_m2reg),
            .sel       (src_sel[g])
        );
        dhu_operand_mux #(.XLEN(XLEN)) u_mux (
            .sel      (src_sel[g]),
            .rf_data  (src_rf[g]),
            .ex_alu   (ex_alu),
            .mem_alu  (mem_alu),
            .mem_load (mem_load),
            .operand  (src_op[g])
        );
    end

    assign fwd_a = src_sel[0];
    assign fwd_b = src_sel[1];
    assign op_a  = src_op[0];
    assign op_b  = src_op[1];

    dhu_load_interlock #(.REG_W(REG_W)) u_lock (
        .id_rs     (id_rs),
        .id_rt     (id_rt),
        .id_use_rs (id_use_rs),
        .id_use_rt (id_use_rt),
        .ex_dst    (ex_dst),
        .ex_wreg   (ex_wreg),
        .ex_m2reg  (ex_m2reg),
        .stall     (stall),
        .front_we  (pc_ifid_we),
        .squash    (cancel)
    );

    logic ex_qual_a;

    always_comb begin
        ex_qual_a = ex_wreg && !ex_m2reg && (ex_dst != '0) && (ex_dst == id_rs);
        if (!$isunknown({id_rs, id_rt, ex_dst, ex_wreg, ex_m2reg, mem_dst,
                         mem_wreg, mem_m2reg, fwd_a, fwd_b, stall})) begin
            // R10
            no_load_ex_fwd_chk: assert (!(ex_m2reg && (fwd_a == 2'd1 || fwd_b == 2'd1)));
            // R5
            zero_reg_fwd_chk: assert (!((id_rs == '0 && fwd_a != 2'd0) || (id_rt == '0 && fwd_b != 2'd0)));
            // R4
            ex_priority_chk: assert (!(ex_qual_a && fwd_a != 2'd1));
            // R6
            stall_needs_load_chk: assert (!stall || (ex_wreg && ex_m2reg && ex_dst != '0));
            // R1
            if (!$isunknown({rf_qa, op_a}) && fwd_a == 2'd0) begin
                regfile_pass_chk: assert (op_a == rf_qa);
            end
        end
    end
endmodule

// File: tb/decode_hazard_unit_tb.sv
module decode_hazard_unit_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [4:0]  id_rs, id_rt, ex_dst, mem_dst;
    logic        id_use_rs, id_use_rt, ex_wreg, ex_m2reg, mem_wreg, mem_m2reg;
    logic [31:0] rf_qa, rf_qb, ex_alu, mem_alu, mem_load;
    logic [1:0]  fwd_a, fwd_b;
    logic [31:0] op_a, op_b;
    logic        stall, pc_ifid_we, cancel;

    int checks = 0;
    int fails  = 0;

    decode_hazard_unit u_dut (.*);

    function automatic int exp_sel(int src);
        if (src != 0 && ex_wreg && !ex_m2reg && int'(ex_dst) == src) return 1;
        if (src != 0 && mem_wreg && int'(mem_dst) == src) return mem_m2reg ? 3 : 2;
        return 0;
    endfunction

    function automatic logic [31:0] exp_op(int sel, logic [31:0] rf);
        case (sel)
            1: return ex_alu;
            2: return mem_alu;
            3: return mem_load;
            default: return rf;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        int sa, sb;
        bit st;
        sa = exp_sel(int'(id_rs));
        sb = exp_sel(int'(id_rt));
        st = ex_wreg && ex_m2reg && ex_dst != 0 &&
             ((id_use_rs && ex_dst == id_rs) || (id_use_rt && ex_dst == id_rt));
        chk({tag, " R2/R3/R4 fwd_a"}, 32'(fwd_a), 32'(sa));
        chk({tag, " R2/R3/R4 fwd_b"}, 32'(fwd_b), 32'(sb));
        chk({tag, " R9 op_a"}, op_a, exp_op(sa, rf_qa));
        chk({tag, " R9 op_b"}, op_b, exp_op(sb, rf_qb));
        chk({tag, " R6 stall"}, 32'(stall), 32'(st));
        chk({tag, " R7 pc_ifid_we"}, 32'(pc_ifid_we), 32'(!st));
        chk({tag, " R8 cancel"}, 32'(cancel), 32'(st));
    endtask

    task automatic set_stages(logic [4:0] rs, logic [4:0] rt, logic urs, logic urt,
                              logic [4:0] ed, logic ew, logic em,
                              logic [4:0] md, logic mw, logic mm);
        @(negedge clk);
        id_rs = rs; id_rt = rt; id_use_rs = urs; id_use_rt = urt;
        ex_dst = ed; ex_wreg = ew; ex_m2reg = em;
        mem_dst = md; mem_wreg = mw; mem_m2reg = mm;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rf_qa = 32'h1111_0001; rf_qb = 32'h2222_0002; ex_alu = 32'hE0E0_E0E0;
        mem_alu = 32'hA0A0_A0A0; mem_load = 32'hD0D0_D0D0;
        // R1 quiet pipe
        set_stages(5'd3, 5'd4, 1, 1, 5'd0, 0, 0, 5'd0, 0, 0);
        chk("R1 fwd_a quiet", 32'(fwd_a), 0);
        chk("R1 op_a quiet", op_a, rf_qa);
        chk("R7 we quiet", 32'(pc_ifid_we), 1);
        // R2 execute ALU match on rt
        set_stages(5'd3, 5'd4, 1, 1, 5'd4, 1, 0, 5'd0, 0, 0);
        chk("R2 fwd_b ex", 32'(fwd_b), 1);
        chk("R2 op_b ex", op_b, ex_alu);
        // R3 memory ALU and load
        set_stages(5'd7, 5'd4, 1, 1, 5'd0, 0, 0, 5'd7, 1, 0);
        chk("R3 fwd_a mem alu", 32'(fwd_a), 2);
        set_stages(5'd7, 5'd4, 1, 1, 5'd0, 0, 0, 5'd7, 1, 1);
        chk("R3 fwd_a mem load", 32'(fwd_a), 3);
        chk("R9 op_a mem load", op_a, mem_load);
        // R4 priority
        set_stages(5'd9, 5'd9, 1, 1, 5'd9, 1, 0, 5'd9, 1, 1);
        chk("R4 fwd_a priority", 32'(fwd_a), 1);
        chk("R4 fwd_b priority", 32'(fwd_b), 1);
        // R5 register zero
        set_stages(5'd0, 5'd0, 1, 1, 5'd0, 1, 0, 5'd0, 1, 1);
        chk("R5 fwd_a zero", 32'(fwd_a), 0);
        chk("R5 fwd_b zero", 32'(fwd_b), 0);
        // R10 load in execute, memory stage also matches
        set_stages(5'd6, 5'd1, 1, 1, 5'd6, 1, 1, 5'd6, 1, 0);
        chk("R10 fwd_a not ex", 32'(fwd_a), 2);
        chk("R6 stall load-use", 32'(stall), 1);
        chk("R7 we during stall", 32'(pc_ifid_we), 0);
        chk("R8 cancel during stall", 32'(cancel), 1);
        // R11 unused source
        set_stages(5'd6, 5'd1, 0, 1, 5'd6, 1, 1, 5'd0, 0, 0);
        chk("R11 no stall unused", 32'(stall), 0);
        chk("R8 no cancel unused", 32'(cancel), 0);
        // R6 load to register zero
        set_stages(5'd0, 5'd0, 1, 1, 5'd0, 1, 1, 5'd0, 0, 0);
        chk("R6 no stall r0", 32'(stall), 0);
        // random reference comparison every cycle
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3));
            id_use_rs = 1'($urandom); id_use_rt = 1'($urandom);
            ex_dst = 5'($urandom_range(0, 3)); ex_wreg = 1'($urandom); ex_m2reg = 1'($urandom);
            mem_dst = 5'($urandom_range(0, 3)); mem_wreg = 1'($urandom); mem_m2reg = 1'($urandom);
            rf_qa = $urandom; rf_qb = $urandom; ex_alu = $urandom;
            mem_alu = $urandom; mem_load = $urandom;
            @(posedge clk);
            #1;
            compare_all("rand");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule